// File: doc/BRIEF.md
# Dual-I/O Serial Flash Read Engine with Continuous Mode

This block is the host side of a serial flash read that sends the address and returns data on two lines at once. A full read frame has four phases. The command byte 0xBB goes out on IO0 alone. The 24-bit address follows on IO0 and IO1 together. A mode byte comes next. The data bytes then come back from the device, two bits per serial clock. The engine drives the serial clock, chip select and the per-line output enables. It takes its input bits on the rising serial clock edge.

The mode byte decides what the device expects in the next frame. If bits 5..4 of the mode byte are `10`, the device stays in continuous read mode. The engine records this in an internal flag. The next frame then leaves out the command byte and starts directly with the address. Any other mode value returns the device to normal operation. An exit operation also leaves continuous mode: it holds both lines high for 16 clocks. Every read request carries a start address, a byte count minus one and a stay-continuous bit. The read bytes leave on a valid/ready byte stream.

Top module: `dio_flash_reader`

## Requirements
- R1: While reset is active, and right after it, chip select (`cs_n`) is high, `sck` is low, both output enables are 0, `dout_valid` is 0 and the continuous flag (`cont_mode`) is 0.
- R2: When `cont_mode` is 0, a read frame starts with 8 serial clocks that carry 0xBB MSB first on IO0. During these clocks `io_oe` is `01`: IO0 is driven and IO1 is not.
- R3: The address takes 12 serial clocks with `io_oe` = `11`. It is sent most significant pair first, with IO1 carrying the higher bit of each pair.
- R4: After the address, the mode byte takes 4 clocks and is sent with the same bit order. Its value is 0x20 when `req_stay` was 1 and 0x00 otherwise.
- R5: Data takes 4 serial clocks per byte with `io_oe` = `00`. IO1 holds the higher bit of each pair, and the first pair is bits 7..6. A request returns `req_len`+1 bytes from consecutive addresses, and the address wraps from 0xFFFFFF to 0. The frame holds exactly (opcode clocks)+16+4·(`req_len`+1) rising `sck` edges.
- R6: A read that sends mode 0x20 sets `cont_mode`. The next read then carries no opcode and begins with the address.
- R7: A read that sends mode 0x00 clears `cont_mode`. The next read then includes the opcode.
- R8: A request with `req_exit`=1 drives IO0 and IO1 high, with both enabled, for exactly 16 serial clocks inside one chip-select frame. It then clears `cont_mode`.
- R9: While `dout_valid` is 1 and `dout_ready` is 0, `dout_data` holds its value. No received byte is lost: the serial clock pauses low until the byte is taken.
- R10: `sck` is low whenever `cs_n` is high. `cs_n` stays high for at least one clock between frames.
- R11: `req_ready` is 1 only while no frame is in progress (`cs_n` high). A request is accepted in a cycle where both `req_valid` and `req_ready` are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; one serial clock period is two system clocks |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Engine idle, request may be taken |
| req_addr | input | 24 | Start byte address |
| req_len | input | LEN_W | Number of bytes to read, minus one |
| req_stay | input | 1 | Send mode 0x20 to keep continuous mode |
| req_exit | input | 1 | Perform the continuous-mode exit instead of a read |
| dout_valid | output | 1 | Received byte available |
| dout_ready | input | 1 | Consumer takes the byte |
| dout_data | output | 8 | Received byte |
| cont_mode | output | 1 | Device is believed to be in continuous mode |
| sck | output | 1 | Serial clock |
| cs_n | output | 1 | Chip select, active low |
| io_o | output | 2 | Output values for IO1 (bit 1) and IO0 (bit 0) |
| io_oe | output | 2 | Output enables for IO1 and IO0 |
| io_i | input | 2 | Input values from IO1 and IO0 |

## Verification
Some rules hold in every cycle, and the assertions check these. The serial clock stays idle outside a frame, and the chip-select gap is always present. IO1 is never driven alone, the flag changes only inside a frame, and a held output byte keeps its value under backpressure. Other behaviour needs whole frames to show, so only the bench scenarios can check it. This covers the exact bit order of opcode, address and mode, and the edge count of each frame. It also covers the byte values from the device, including address wrap, and the rule that the opcode is dropped or restored depending on the previous frame's mode byte. The bench gets these values from a model of the device on the serial lines.

// File: rtl/dio_flash_reader.sv
module dio_flash_reader #(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [23:0]      req_addr,
  input  logic [LEN_W-1:0] req_len,
  input  logic             req_stay,
  input  logic             req_exit,
  output logic             dout_valid,
  input  logic             dout_ready,
  output logic [7:0]       dout_data,
  output logic             cont_mode,
  output logic             sck,
  output logic             cs_n,
  output logic [1:0]       io_o,
  output logic [1:0]       io_oe,
  input  logic [1:0]       io_i
);
  localparam logic [7:0] OPCODE    = 8'hBB;
  localparam logic [7:0] MODE_KEEP = 8'h20;
  localparam logic [7:0] MODE_DROP = 8'h00;
  localparam int         ADDR_CLKS = 12;
  localparam int         MODE_CLKS = 4;
  localparam int         EXIT_CLKS = 16;

  typedef enum logic [2:0] {S_IDLE, S_CMD, S_ADDR, S_MODE, S_DATA, S_EXIT, S_END} st_t;

  st_t              st;
  logic             ph;
  logic [3:0]       cnt;
  logic [LEN_W-1:0] left;
  logic [31:0]      tx;
  logic [5:0]       rx;
  logic             stay_r;
  logic             cont_r;
  logic             dv;
  logic [7:0]       dd;

  wire active    = (st != S_IDLE) && (st != S_END);
  wire last_pair = (cnt[1:0] == 2'd3);
  wire stall     = (st == S_DATA) && !ph && last_pair && dv && !dout_ready;
  wire cap       = (st == S_DATA) && !ph && !stall;
  wire adv       = active && ph;

  assign req_ready  = (st == S_IDLE);
  assign cs_n       = (st == S_IDLE) || (st == S_END);
  assign sck        = ph;
  assign dout_valid = dv;
  assign dout_data  = dd;
  assign cont_mode  = cont_r;

  always_comb begin
    io_o  = 2'b00;
    io_oe = 2'b00;
    case (st)
      S_CMD:          begin io_o = {1'b0, OPCODE[3'd7 - cnt[2:0]]}; io_oe = 2'b01; end
      S_ADDR, S_MODE: begin io_o = tx[31:30]; io_oe = 2'b11; end
      S_EXIT:         begin io_o = 2'b11;     io_oe = 2'b11; end
      default:        ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      ph     <= 1'b0;
      cnt    <= '0;
      left   <= '0;
      tx     <= '0;
      rx     <= '0;
      stay_r <= 1'b0;
      cont_r <= 1'b0;
      dv     <= 1'b0;
      dd     <= '0;
    end else begin
      if (cap && last_pair) begin
        dd <= {rx, io_i};
        dv <= 1'b1;
      end else if (dout_ready) begin
        dv <= 1'b0;
      end
      if (cap) rx <= {rx[3:0], io_i};
      if (active && !stall) ph <= ~ph;

      case (st)
        S_IDLE: if (req_valid) begin
          cnt    <= '0;
          tx     <= {req_addr, req_stay ? MODE_KEEP : MODE_DROP};
          left   <= req_len;
          stay_r <= req_stay;
          st     <= req_exit ? S_EXIT : (cont_r ? S_ADDR : S_CMD);
        end
        S_CMD: if (adv) begin
          cnt <= cnt + 4'd1;
          if (cnt == 4'd7) begin cnt <= '0; st <= S_ADDR; end
        end
        S_ADDR: if (adv) begin
          tx  <= {tx[29:0], 2'b00};
          cnt <= cnt + 4'd1;
          if (cnt == 4'(ADDR_CLKS - 1)) begin cnt <= '0; st <= S_MODE; end
        end
        S_MODE: if (adv) begin
          tx  <= {tx[29:0], 2'b00};
          cnt <= cnt + 4'd1;
          if (cnt == 4'(MODE_CLKS - 1)) begin
            cnt    <= '0;
            st     <= S_DATA;
            cont_r <= stay_r;
          end
        end
        S_DATA: if (adv) begin
          cnt <= cnt + 4'd1;
          if (last_pair) begin
            if (left == '0) st <= S_END;
            else left <= left - 1'b1;
          end
        end
        S_EXIT: if (adv) begin
          cnt <= cnt + 4'd1;
          if (cnt == 4'(EXIT_CLKS - 1)) begin st <= S_END; cont_r <= 1'b0; end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dio_flash_reader_chk.sv
module dio_flash_reader_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_ready,
  input logic       dout_valid,
  input logic       dout_ready,
  input logic [7:0] dout_data,
  input logic       cont_mode,
  input logic       sck,
  input logic       cs_n,
  input logic [1:0] io_oe
);
  a_r10_sck_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sck);

  a_r10_cs_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |=> cs_n);

  a_r11_ready_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> cs_n);

  a_r9_hold_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_valid && !dout_ready) |=> (dout_valid && $stable(dout_data)));

  a_r2_io1_not_alone: assert property (@(posedge clk) disable iff (!rst_n)
    io_oe != 2'b10);

  a_r6_flag_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    $changed(cont_mode) |-> $past(!cs_n));
endmodule

bind dio_flash_reader dio_flash_reader_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .dout_valid(dout_valid),
  .dout_ready(dout_ready), .dout_data(dout_data), .cont_mode(cont_mode),
  .sck(sck), .cs_n(cs_n), .io_oe(io_oe)
);

// File: tb/dio_flash_reader_bench.sv
module dio_flash_reader_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        req_valid = 1'b0, req_stay = 1'b0, req_exit = 1'b0;
  logic        req_ready;
  logic [23:0] req_addr = '0;
  logic [7:0]  req_len = '0;
  logic        dout_valid, dout_ready = 1'b1;
  logic [7:0]  dout_data;
  logic        cont_mode, sck, cs_n;
  logic [1:0]  io_o, io_oe, io_i;

  dio_flash_reader #(.LEN_W(8)) u_dio_flash_reader (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_len(req_len), .req_stay(req_stay), .req_exit(req_exit),
    .dout_valid(dout_valid), .dout_ready(dout_ready), .dout_data(dout_data),
    .cont_mode(cont_mode), .sck(sck), .cs_n(cs_n), .io_o(io_o), .io_oe(io_oe), .io_i(io_i)
  );

  int checks = 0, fails = 0;
  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] mem(logic [23:0] a);
    return (a[7:0] * 8'd7) + (a[15:8] ^ a[23:16]) + 8'h3C;
  endfunction

  // device model on the serial lines
  logic [1:0] rec_io [0:127];
  logic [1:0] rec_oe [0:127];
  int   e = 0, frame_e = 0;
  bit   dev_cont = 1'b0;
  logic [1:0] drv = 2'b00;
  assign io_i = drv;

  function automatic logic [23:0] addr_from(int base);
    logic [23:0] a = '0;
    for (int i = 0; i < 12; i++) a = {a[21:0], rec_io[base + i]};
    return a;
  endfunction

  always @(negedge cs_n) e = 0;
  always @(posedge sck) begin
    if (e < 128) begin rec_io[e] = io_o; rec_oe[e] = io_oe; end
    e++;
  end
  always @(negedge sck) begin
    int h, k;
    logic [7:0] b;
    h = dev_cont ? 16 : 24;
    if (e >= h) begin
      k = e - h;
      b = mem(addr_from(h - 16) + 24'(k / 4));
      drv = b[7 - 2*(k % 4) -: 2];
    end else drv = 2'b00;
  end
  always @(posedge cs_n) begin
    int h;
    bit ones;
    frame_e = e;
    h = dev_cont ? 16 : 24;
    ones = 1'b1;
    for (int i = 0; i < 16 && i < e; i++) if (rec_io[i] != 2'b11) ones = 1'b0;
    if (e == 16 && ones) dev_cont = 1'b0;
    else if (e >= h) dev_cont = (rec_io[h - 3] == 2'b10);
  end

  // consumer and per-cycle observation
  logic [7:0] got [0:63];
  int  ngot = 0, cyc = 0;
  bit  throttle = 1'b0, hold_err = 1'b0, sck_err = 1'b0;
  bit  pv = 1'b0, pr = 1'b1;
  logic [7:0] pd = '0;
  always @(negedge clk) begin
    cyc++;
    if (rst_n && pv && !pr && (!dout_valid || dout_data != pd)) hold_err = 1'b1;
    if (cs_n && sck) sck_err = 1'b1;
    dout_ready = throttle ? (cyc % 3 == 0) : 1'b1;
    if (dout_valid && dout_ready && ngot < 64) begin got[ngot] = dout_data; ngot++; end
    pv = dout_valid; pr = dout_ready; pd = dout_data;
    if (cyc > 190000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  bit exp_cont = 1'b0;

  task automatic issue(logic [23:0] a, logic [7:0] len, bit stay, bit ex);
    @(negedge clk);
    req_addr = a; req_len = len; req_stay = stay; req_exit = ex; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic do_read(logic [23:0] a, logic [7:0] len, bit stay, bit thr);
    int h, n;
    logic [7:0] v;
    bit ok;
    throttle = thr; ngot = 0; hold_err = 0; sck_err = 0;
    issue(a, len, stay, 1'b0);
    do @(negedge clk); while (!req_ready || ngot < int'(len) + 1);
    n = int'(len) + 1;
    h = exp_cont ? 16 : 24;
    chk(frame_e == h + 4*n, exp_cont ? "R6 edges without opcode" : "R5 edge count", frame_e, h + 4*n);
    if (!exp_cont) begin
      v = '0; ok = 1'b1;
      for (int i = 0; i < 8; i++) begin v = {v[6:0], rec_io[i][0]}; if (rec_oe[i] != 2'b01) ok = 1'b0; end
      chk(v == 8'hBB && ok, exp_cont ? "R6 opcode" : "R7 R2 opcode", {ok, v}, 9'h1BB);
    end
    ok = 1'b1;
    for (int i = h - 16; i < h; i++) if (rec_oe[i] != 2'b11) ok = 1'b0;
    chk(addr_from(h - 16) == a && ok, "R3 address", addr_from(h - 16), a);
    v = {rec_io[h-4], rec_io[h-3], rec_io[h-2], rec_io[h-1]};
    chk(v == (stay ? 8'h20 : 8'h00), "R4 mode byte", v, stay ? 8'h20 : 8'h00);
    for (int i = 0; i < n; i++)
      chk(got[i] == mem(a + 24'(i)), "R5 data byte", got[i], mem(a + 24'(i)));
    ok = 1'b1;
    for (int i = h; i < h + 4*n; i++) if (rec_oe[i] != 2'b00) ok = 1'b0;
    chk(ok, "R5 lines released", ok, 1);
    chk(cont_mode == stay, stay ? "R6 flag set" : "R7 flag cleared", cont_mode, stay);
    if (thr) chk(!hold_err, "R9 held byte", hold_err, 0);
    chk(!sck_err, "R10 sck idle", sck_err, 0);
    exp_cont = stay;
  endtask

  task automatic do_exit();
    bit ok;
    sck_err = 0;
    issue(24'h0, 8'h0, 1'b0, 1'b1);
    do @(negedge clk); while (!req_ready);
    ok = 1'b1;
    for (int i = 0; i < 16; i++) if (rec_io[i] != 2'b11 || rec_oe[i] != 2'b11) ok = 1'b0;
    chk(frame_e == 16 && ok, "R8 exit pattern", {ok, frame_e[7:0]}, 9'h110);
    chk(cont_mode == 1'b0, "R8 flag cleared", cont_mode, 0);
    chk(!sck_err, "R10 sck idle", sck_err, 0);
    exp_cont = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(cs_n && !sck && io_oe == 2'b00 && !dout_valid && !cont_mode,
        "R1 reset state", {cs_n, sck, io_oe, dout_valid, cont_mode}, 6'b100000);
    chk(req_ready, "R11 ready in reset", req_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cs_n && !sck && !cont_mode, "R1 after reset", {cs_n, sck, cont_mode}, 3'b100);
    for (int len = 0; len < 8; len++) begin
      for (int s = 0; s < 4; s++) begin
        logic [23:0] a;
        a = 24'hFFFFF8 + 24'(len * 37) + 24'(s * 5);
        do_read(a, 8'(len), s[0], s[1]);
        do_read(a ^ 24'h5A5A5, 8'(len), 1'b1, s[1]);
        do_read(a + 24'h123456, 8'(len), s[0], !s[1]);
        if ((len + s) % 2 == 1) do_exit();
      end
    end
    do_read(24'hFFFFFE, 8'd5, 1'b1, 1'b0);
    do_exit();
    do_read(24'h000010, 8'd2, 1'b0, 1'b1);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule